// File: doc/BRIEF.md
# Dual Interval Timer with Latches

This block holds two 16-bit down-counters. A processor reaches them through a byte-wide register port on a 4-bit address bus. The block runs from one clock at twice the bus cycle rate. An internal phase bit divides each bus cycle into two halves. Register accesses are taken on the edge that closes the first half. Counting, loading and overflow detection happen on the edge that closes the second half.

Timer A reloads from a 16-bit latch. It can stop flagging after its first overflow, or it can reload and flag again on every overflow. Timer B has only a low-byte latch. Writing its high byte starts it with that byte over the latched low byte. A counter write does not change the count at once. The new value waits in a pending slot and overwrites the count after that cycle's decrement. An overflow flag becomes visible on the interrupt pin half a cycle after it is set, through a flag register and an enable mask.

Top module: `dual_timer`

## Requirements
- R1: After reset both flags, both enables, the mode bit, both latches and both pending slots are clear. The interrupt output reads 0. Register 13 reads 0x00, register 14 reads 0x80, and registers 11 and 6 read 0x00.
- R2: The `phase` output is low for the first half of each bus cycle and high for the second half. After reset is released it starts low. A bus access is taken only on the clock edge where `phase` is low.
- R3: Writing register 5 stores the byte in the high half of the timer A latch. It places {byte, latch low} in timer A's pending slot, clears the timer A flag and arms timer A.
- R4: Writing register 8 changes only the timer B low latch. The timer B count read through registers 8 and 9 goes on decrementing untouched.
- R5: Writing register 9 places {byte, timer B low latch} in timer B's pending slot, clears the timer B flag and arms timer B. With low latch 0x40 and a write of 0x50, the next two cycles read 0x40 from register 8 and then 0x50 from register 9.
- R6: A pending value replaces the counter at the end of the cycle in which it was written, after that cycle's decrement. The next cycle reads it back exactly. The count passing zero in that same cycle raises no flag.
- R7: A timer's flag is set at the end of the cycle in which its count was 0, if it is armed. The interrupt output follows on the next access edge, half a cycle later. A load of N gives the flag N+1 cycles after the load cycle.
- R8: When register 11 bit 6 is 0, timer A flags only on its first overflow after a load. The count then wraps to 0xFFFF and keeps decrementing without further flags.
- R9: When register 11 bit 6 is 1, timer A reloads from its latch on each overflow and flags every N+1 cycles.
- R10: Timer B decrements once per cycle, wraps from 0 to 0xFFFF, and flags once per load.
- R11: Register 13 reads timer A's flag in bit 6, timer B's flag in bit 5, and the OR of enabled flags in bit 7. Reading register 4 returns the timer A count low byte and clears the timer A flag.
- R12: Writing register 14 with bit 7 set sets the enables selected by bits 6 and 5. With bit 7 clear it clears them. Register 14 reads {1, enable A, enable B, 00000}.
- R13: The interrupt output is the OR of the flags ANDed with their enables. It is registered on access edges, so a flag that is not enabled never raises it.
- R14: Registers 6 and 7 write the timer A latch low and high bytes without touching the count, and read them back. Register 11 reads back bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus cycle rate |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, taken while phase is low |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register number |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| phase | output | 1 | Half-cycle indicator, high in the second half |
| irq | output | 1 | Active-high interrupt request |

## Verification
The sharp collision is a high-byte write to timer A landing in the very cycle its count passes through zero. Then a load and an overflow contend for the same edge. The bench arms timer A with a count of 2 and waits until the count reads 0. It writes register 5 in that cycle. It then checks that no flag appears in the next cycle, that the count continues from the reloaded value, and that the flag arrives only after the new count runs out.

// File: rtl/dual_timer_pkg.sv
package dual_timer_pkg;
  localparam int REG_TA_CNT_LO = 4;
  localparam int REG_TA_CNT_HI = 5;
  localparam int REG_TA_LAT_LO = 6;
  localparam int REG_TA_LAT_HI = 7;
  localparam int REG_TB_LO     = 8;
  localparam int REG_TB_HI     = 9;
  localparam int REG_MODE      = 11;
  localparam int REG_FLAGS     = 13;
  localparam int REG_ENABLE    = 14;
endpackage

// File: rtl/dual_timer_phase.sv
module dual_timer_phase (
  input  logic clk,
  input  logic rst,
  output logic phase
);
  always_ff @(posedge clk) begin
    if (rst) phase <= 1'b0;
    else     phase <= ~phase;
  end
endmodule

// File: rtl/dual_timer_cnt.sv
module dual_timer_cnt #(
  parameter int W         = 16,
  parameter bit RELOAD_EN = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         load_stb,
  input  logic [W-1:0] load_val,
  input  logic         auto_reload,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] count,
  output logic         wrap,
  output logic         pending,
  output logic [W-1:0] pend_val
);
  logic [W-1:0] stepped;

  generate
    if (RELOAD_EN) begin : g_reload
      always_comb stepped = (count == '0 && auto_reload) ? reload_val : count - W'(1);
    end else begin : g_free
      logic unused_ok;
      assign unused_ok = &{1'b0, auto_reload, reload_val};
      always_comb stepped = count - W'(1);
    end
  endgenerate

  // overflow seen only when no pending value is about to overwrite the count
  assign wrap = tick && (count == '0) && !pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      pending  <= 1'b0;
      pend_val <= '0;
    end else begin
      if (load_stb) begin
        pend_val <= load_val;
        pending  <= 1'b1;
      end
      if (tick) begin
        count   <= pending ? pend_val : stepped;
        pending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import dual_timer_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              phase,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;
  localparam int B_ANY = DATA_W - 1;
  localparam int B_TA  = DATA_W - 2;
  localparam int B_TB  = DATA_W - 3;

  logic acc, wr, rd;
  int   ra;
  logic [CNT_W-1:0]  ta_latch;
  logic [DATA_W-1:0] tb_lo_latch;
  logic              cont_mode;
  logic [1:0]        ien;          // [1] timer A, [0] timer B
  logic              t1_flag, t2_flag, t1_run, t2_run;
  logic              t1_load, t2_load, rd_ta_lo;
  logic [CNT_W-1:0]  t1_count, t2_count, t1_pval, t2_pval;
  logic              t1_wrap, t2_wrap, t1_pend, t2_pend;
  logic              any_on;
  logic [DATA_W-1:0] rd_mux;

  dual_timer_phase u_phase (.clk(clk), .rst(rst), .phase(phase));

  assign acc = bus_sel & ~phase;
  assign wr  = acc & bus_we;
  assign rd  = acc & ~bus_we;
  assign ra  = int'(bus_addr);

  assign t1_load  = wr & (ra == REG_TA_CNT_HI);
  assign t2_load  = wr & (ra == REG_TB_HI);
  assign rd_ta_lo = rd & (ra == REG_TA_CNT_LO);

  dual_timer_cnt #(.W(CNT_W), .RELOAD_EN(1'b1)) u_ta (
    .clk(clk), .rst(rst), .tick(phase),
    .load_stb(t1_load), .load_val({bus_wdata, ta_latch[DATA_W-1:0]}),
    .auto_reload(cont_mode), .reload_val(ta_latch),
    .count(t1_count), .wrap(t1_wrap), .pending(t1_pend), .pend_val(t1_pval)
  );

  dual_timer_cnt #(.W(CNT_W), .RELOAD_EN(1'b0)) u_tb (
    .clk(clk), .rst(rst), .tick(phase),
    .load_stb(t2_load), .load_val({bus_wdata, tb_lo_latch}),
    .auto_reload(1'b0), .reload_val('0),
    .count(t2_count), .wrap(t2_wrap), .pending(t2_pend), .pend_val(t2_pval)
  );

  // latches, mode and enable mask
  always_ff @(posedge clk) begin
    if (rst) begin
      ta_latch    <= '0;
      tb_lo_latch <= '0;
      cont_mode   <= 1'b0;
      ien         <= '0;
    end else if (wr) begin
      if (ra == REG_TA_CNT_LO || ra == REG_TA_LAT_LO) ta_latch[DATA_W-1:0]     <= bus_wdata;
      if (ra == REG_TA_CNT_HI || ra == REG_TA_LAT_HI) ta_latch[CNT_W-1:DATA_W] <= bus_wdata;
      if (ra == REG_TB_LO)  tb_lo_latch <= bus_wdata;
      if (ra == REG_MODE)   cont_mode   <= bus_wdata[B_TA];
      if (ra == REG_ENABLE) begin
        if (bus_wdata[B_ANY]) ien <= ien |  {bus_wdata[B_TA], bus_wdata[B_TB]};
        else                  ien <= ien & ~{bus_wdata[B_TA], bus_wdata[B_TB]};
      end
    end
  end

  // flags, arming and the half-cycle-late interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      t1_flag <= 1'b0;
      t2_flag <= 1'b0;
      t1_run  <= 1'b0;
      t2_run  <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (t1_wrap && t1_run)          t1_flag <= 1'b1;
      else if (t1_load || rd_ta_lo)   t1_flag <= 1'b0;
      if (t2_wrap && t2_run)          t2_flag <= 1'b1;
      else if (t2_load)               t2_flag <= 1'b0;
      if (t1_load)                    t1_run  <= 1'b1;
      else if (t1_wrap && !cont_mode) t1_run  <= 1'b0;
      if (t2_load)                    t2_run  <= 1'b1;
      else if (t2_wrap)               t2_run  <= 1'b0;
      if (!phase)                     irq     <= any_on;
    end
  end

  assign any_on = |({t1_flag, t2_flag} & ien);

  always_comb begin
    rd_mux = '0;
    case (ra)
      REG_TA_CNT_LO: rd_mux = t1_count[DATA_W-1:0];
      REG_TA_CNT_HI: rd_mux = t1_count[CNT_W-1:DATA_W];
      REG_TA_LAT_LO: rd_mux = ta_latch[DATA_W-1:0];
      REG_TA_LAT_HI: rd_mux = ta_latch[CNT_W-1:DATA_W];
      REG_TB_LO:     rd_mux = t2_count[DATA_W-1:0];
      REG_TB_HI:     rd_mux = t2_count[CNT_W-1:DATA_W];
      REG_MODE: begin
        rd_mux[B_TA] = cont_mode;
      end
      REG_FLAGS: begin
        rd_mux[B_ANY] = any_on;
        rd_mux[B_TA]  = t1_flag;
        rd_mux[B_TB]  = t2_flag;
      end
      REG_ENABLE: begin
        rd_mux[B_ANY] = 1'b1;
        rd_mux[B_TA]  = ien[1];
        rd_mux[B_TB]  = ien[0];
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk
  import dual_timer_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              phase,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              irq,
  input logic [CNT_W-1:0]  t1_count,
  input logic [CNT_W-1:0]  t2_count,
  input logic [CNT_W-1:0]  t1_pval,
  input logic [CNT_W-1:0]  t2_pval,
  input logic              t1_pend,
  input logic              t2_pend,
  input logic              t1_flag,
  input logic              t2_flag,
  input logic              t1_run
);
  logic wr_now;
  assign wr_now = bus_sel && !phase && bus_we;

  assert_irq_half_R7: assert property (@(posedge clk) disable iff (rst)
    phase |=> $stable(irq));

  assert_counts_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !phase |=> ($stable(t1_count) && $stable(t2_count)));

  assert_ta_load_R6: assert property (@(posedge clk) disable iff (rst)
    (phase && t1_pend) |=> (t1_count == $past(t1_pval)));

  assert_tb_load_R6: assert property (@(posedge clk) disable iff (rst)
    (phase && t2_pend) |=> (t2_count == $past(t2_pval)));

  assert_tb_step_R10: assert property (@(posedge clk) disable iff (rst)
    (phase && !t2_pend) |=> (t2_count == $past(t2_count) - CNT_W'(1)));

  assert_ta_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_now && int'(bus_addr) == REG_TA_CNT_HI) |=> !t1_flag);

  assert_tb_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_now && int'(bus_addr) == REG_TB_HI) |=> !t2_flag);

  assert_flag_armed_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(t1_flag) |-> $past(t1_run));
endmodule

bind dual_timer dual_timer_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .phase(phase), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .irq(irq), .t1_count(t1_count), .t2_count(t2_count),
  .t1_pval(t1_pval), .t2_pval(t2_pval), .t1_pend(t1_pend), .t2_pend(t2_pend),
  .t1_flag(t1_flag), .t2_flag(t2_flag), .t1_run(t1_run)
);

// File: tb/dual_timer_test.sv
module dual_timer_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0;
  logic       bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       phase;
  logic       irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] rv;

  dual_timer uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .phase(phase), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_acc();
    while (phase) @(negedge clk);
  endtask

  task automatic bus_wr(input int a, input logic [7:0] d);
    wait_acc();
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 4'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input int a, output logic [7:0] d);
    wait_acc();
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 4'(a);
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic skip(input int n);
    for (int i = 0; i < n; i++) begin
      wait_acc();
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R2 phase low after reset", {7'd0, phase}, 8'h00);
    chk("R1 irq after reset", {7'd0, irq}, 8'h00);
    @(negedge clk);
    chk("R2 phase high second half", {7'd0, phase}, 8'h01);
    bus_rd(13, rv); chk("R1 flags", rv, 8'h00);
    bus_rd(14, rv); chk("R1 enables", rv, 8'h80);
    bus_rd(11, rv); chk("R1 mode", rv, 8'h00);
    bus_rd(6, rv);  chk("R1 latch low", rv, 8'h00);
  endtask

  task automatic t_latch();
    do_reset();
    bus_wr(6, 8'h34);
    bus_wr(7, 8'h12);
    bus_rd(7, rv); chk("R14 latch high", rv, 8'h12);
    bus_rd(6, rv); chk("R14 latch low", rv, 8'h34);
    bus_rd(5, rv); chk("R14 count untouched", rv, 8'hFF);
    bus_wr(11, 8'h40);
    bus_rd(11, rv); chk("R14 mode readback", rv, 8'h40);
    bus_wr(4, 8'h22);
    bus_wr(5, 8'h11);
    bus_rd(7, rv); chk("R3 latch high from reg5", rv, 8'h11);
    bus_rd(5, rv); chk("R3 count high", rv, 8'h11);
    bus_rd(4, rv); chk("R6 count low after two steps", rv, 8'h20);
  endtask

  task automatic t_ta_oneshot();
    do_reset();
    bus_wr(14, 8'hC0);
    bus_wr(4, 8'd10);
    bus_wr(5, 8'd0);
    bus_rd(4, rv); chk("R6 loaded value", rv, 8'd10);
    skip(9);
    bus_rd(4, rv); chk("R7 count reaches zero", rv, 8'd0);
    @(negedge clk);
    chk("R7 irq not before half cycle", {7'd0, irq}, 8'h00);
    bus_rd(13, rv); chk("R11 flag register", rv, 8'hC0);
    chk("R7 irq half cycle after", {7'd0, irq}, 8'h01);
    bus_rd(5, rv); chk("R8 wrap high byte", rv, 8'hFF);
    bus_rd(4, rv); chk("R8 wrap low byte", rv, 8'hFD);
    bus_rd(13, rv); chk("R11 read clears flag", rv, 8'h00);
    chk("R13 irq drops", {7'd0, irq}, 8'h00);
    skip(20);
    bus_rd(13, rv); chk("R8 no second flag", rv, 8'h00);
  endtask

  task automatic t_ta_cont();
    do_reset();
    bus_wr(11, 8'h40);
    bus_wr(4, 8'd4);
    bus_wr(5, 8'd0);
    skip(5);
    bus_rd(13, rv); chk("R13 flag without enable", rv, 8'h40);
    chk("R13 irq masked", {7'd0, irq}, 8'h00);
    bus_rd(4, rv); chk("R9 reload from latch", rv, 8'd3);
    skip(2);
    bus_rd(13, rv); chk("R9 no flag early", rv, 8'h00);
    bus_rd(13, rv); chk("R9 second flag", rv, 8'h40);
    bus_wr(5, 8'd0);
    bus_rd(13, rv); chk("R3 write clears flag", rv, 8'h00);
  endtask

  task automatic t_tb_latch();
    do_reset();
    bus_wr(8, 8'h10);
    bus_wr(9, 8'h20);
    bus_wr(8, 8'h40);
    bus_rd(8, rv); chk("R4 count low unchanged", rv, 8'h0F);
    bus_rd(9, rv); chk("R4 count high unchanged", rv, 8'h20);
    bus_wr(9, 8'h50);
    bus_rd(8, rv); chk("R5 low from latch", rv, 8'h40);
    bus_rd(9, rv); chk("R5 high from write", rv, 8'h50);
  endtask

  task automatic t_tb_wrap();
    do_reset();
    bus_wr(14, 8'hA0);
    bus_wr(8, 8'd3);
    bus_wr(9, 8'd0);
    skip(4);
    bus_rd(13, rv); chk("R10 timer B flag", rv, 8'hA0);
    chk("R7 irq from timer B", {7'd0, irq}, 8'h01);
    bus_rd(8, rv); chk("R10 wrap low", rv, 8'hFE);
    bus_rd(9, rv); chk("R10 wrap high", rv, 8'hFF);
    bus_wr(9, 8'd0);
    bus_rd(13, rv); chk("R5 write clears flag", rv, 8'h00);
    chk("R5 irq cleared", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_enable();
    do_reset();
    bus_wr(14, 8'hE0);
    bus_rd(14, rv); chk("R12 set both", rv, 8'hE0);
    bus_wr(14, 8'h40);
    bus_rd(14, rv); chk("R12 clear A", rv, 8'hA0);
    bus_wr(14, 8'h00);
    bus_rd(14, rv); chk("R12 empty clear", rv, 8'hA0);
    bus_wr(14, 8'h20);
    bus_rd(14, rv); chk("R12 clear B", rv, 8'h80);
  endtask

  task automatic t_collide();
    do_reset();
    bus_wr(14, 8'hC0);
    bus_wr(4, 8'd2);
    bus_wr(5, 8'd0);
    skip(2);
    bus_wr(5, 8'd0);
    bus_rd(13, rv); chk("R6 load beats overflow", rv, 8'h00);
    bus_rd(4, rv);  chk("R6 count after collision", rv, 8'd1);
    bus_rd(13, rv); chk("R6 no flag yet", rv, 8'h00);
    bus_rd(13, rv); chk("R7 flag after new count", rv, 8'hC0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_latch();
    t_ta_oneshot();
    t_ta_cont();
    t_tb_latch();
    t_tb_wrap();
    t_enable();
    t_collide();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule